// File: doc/BRIEF.md
# Delayed-Branch Next-PC and Annul Unit

This block decides where a 32-bit processor with a single branch delay slot fetches next. It keeps the address of the instruction now executing and the address of the one after it in two registers. Each time the strobe is high it takes the instruction word at the current address and makes one step. Integer conditional branches test four condition flags (negative, zero, overflow, carry) supplied from outside. A PC-relative call always writes its link to a fixed register. A register-indirect jump-and-link uses an address sum formed outside the block and writes its link to a register that the instruction selects.

Because of the delay slot, a taken transfer does not take effect on the next fetch. The instruction that follows the branch runs first, and only then does the target become the fetch address. Each branch carries an annul bit. When that bit is set, the block raises a squash signal for the delay-slot instruction if the branch is not taken. It also raises it for an unconditional branch, where the slot is dropped even though the branch is taken.

Top module: `brx_top`

## Requirements
- R1: A synchronous active-high reset sets the current address `curPc` to 0 and the following address `nextPc` to 4.
- R2: With `instValid` high and no transfer, `curPc` takes the old `nextPc` and `nextPc` advances by 4. With `instValid` low, both registers hold their values.
- R3: A conditional branch has bits [31:30]=00 and bits [24:22]=010. Its condition field is bits [28:25], with these codes: 0 never, 1 Z, 2 Z|(N^V), 3 N^V, 4 C|Z, 5 C, 6 N, 7 V. Codes 8 to F are the inverses of codes 0 to 7 in the same order (8 always, 9 not equal, A greater, B greater-or-equal, C greater unsigned, D carry clear, E positive, F overflow clear). `taken` is high in the same cycle exactly when the condition holds.
- R4: For a taken branch, the target is `curPc` plus the sign-extended 22-bit word displacement in bits [21:0], shifted left by two. On the step, `curPc` takes the old `nextPc` (the delay slot) and `nextPc` takes the target.
- R5: The annul bit is bit 29 of a branch. If it is 0, `annul` stays low. If it is 1 and the branch is not taken, `annul` is high.
- R6: For code 8 (always) with the annul bit set, `taken` and `annul` are both high. For any other condition that is taken, `annul` is low.
- R7: A call has bits [31:30]=01. Its target is `curPc` plus bits [29:0] shifted left by two. It asserts `linkWe` with `linkIdx`=15 and `linkData`=`curPc`, and is always taken.
- R8: A jump-and-link has bits [31:30]=10 and bits [24:19]=111000. Its target is the `jmpSum` input. It asserts `linkWe` with `linkIdx` equal to bits [29:25] and `linkData`=`curPc`.
- R9: When `instValid` is low, or when the word is none of the three transfer kinds, `taken`, `annul` and `linkWe` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instValid | input | 1 | Step strobe; the instruction word is valid |
| instWord | input | 32 | Instruction at `curPc` |
| flagN | input | 1 | Negative flag |
| flagZ | input | 1 | Zero flag |
| flagV | input | 1 | Overflow flag |
| flagC | input | 1 | Carry flag |
| jmpSum | input | 32 | Sum of the two jump-and-link address operands |
| curPc | output | 32 | Address of the instruction now executing |
| nextPc | output | 32 | Address fetched after it |
| taken | output | 1 | A transfer is taken this step |
| annul | output | 1 | Squash the delay-slot instruction |
| linkWe | output | 1 | Link write request |
| linkIdx | output | 5 | Link destination register |
| linkData | output | 32 | Return address to write |

## Verification
The properties assume that `instWord` and `jmpSum` are stable and meaningful whenever `instValid` is sampled high. They also assume that the flags at that edge belong to the branch being resolved. The bench changes every input only at the falling clock edge and holds it through the following rising edge, so those assumptions hold. It never lets reset coincide with a strobe, except for the initial reset. Branch displacements are chosen to wrap freely across the 32-bit space, since the properties use modular addition just as the datapath does.

// File: rtl/brx_pkg.sv
package brx_pkg;

  typedef enum logic [1:0] {
    TGT_BRANCH = 2'd0,
    TGT_CALL   = 2'd1,
    TGT_REG    = 2'd2
  } tgtSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    take;
    tgtSel_e tgtSel;
  } ctlStrobe_t;

  localparam logic [1:0] OP_BRANCH = 2'b00;
  localparam logic [1:0] OP_CALL   = 2'b01;
  localparam logic [1:0] OP_ARITH  = 2'b10;
  localparam logic [2:0] OP2_ICC   = 3'b010;
  localparam logic [5:0] OP3_JMPL  = 6'b111000;
  localparam logic [3:0] COND_ALWAYS = 4'h8;

  // low three bits pick the base test, bit 3 inverts it
  function automatic logic evalCond(input logic [3:0] code, input logic n,
                                    input logic z, input logic v, input logic c);
    logic base;
    unique case (code[2:0])
      3'd0: base = 1'b0;
      3'd1: base = z;
      3'd2: base = z | (n ^ v);
      3'd3: base = n ^ v;
      3'd4: base = c | z;
      3'd5: base = c;
      3'd6: base = n;
      default: base = v;
    endcase
    return base ^ code[3];
  endfunction

endpackage

// File: rtl/brx_control.sv
module brx_control
  import brx_pkg::*;
#(
  parameter int HI_LSB   = 19,
  parameter int LINK_REG = 15
) (
  input  logic                instValid,
  input  logic [31:HI_LSB]    instHi,
  input  logic                flagN,
  input  logic                flagZ,
  input  logic                flagV,
  input  logic                flagC,
  output ctlStrobe_t          strobe,
  output logic                annul,
  output logic                linkWe,
  output logic [4:0]          linkIdx
);

  logic [1:0] opField;
  logic [2:0] op2Field;
  logic [5:0] op3Field;
  logic [3:0] condField;
  logic [4:0] rdField;
  logic       annulBit;
  logic       isBranch, isCall, isJmpl, condHit;

  assign opField   = instHi[31:30];
  assign annulBit  = instHi[29];
  assign rdField   = instHi[29:25];
  assign condField = instHi[28:25];
  assign op2Field  = instHi[24:22];
  assign op3Field  = instHi[24:19];

  assign isBranch = (opField == OP_BRANCH) && (op2Field == OP2_ICC);
  assign isCall   = (opField == OP_CALL);
  assign isJmpl   = (opField == OP_ARITH) && (op3Field == OP3_JMPL);
  assign condHit  = evalCond(condField, flagN, flagZ, flagV, flagC);

  always_comb begin
    strobe.take = instValid & ((isBranch & condHit) | isCall | isJmpl);
    if (isCall)      strobe.tgtSel = TGT_CALL;
    else if (isJmpl) strobe.tgtSel = TGT_REG;
    else             strobe.tgtSel = TGT_BRANCH;
  end

  assign annul   = instValid & isBranch & annulBit &
                   (~condHit | (condField == COND_ALWAYS));
  assign linkWe  = instValid & (isCall | isJmpl);
  assign linkIdx = isCall ? 5'(LINK_REG) : rdField;

endmodule

// File: rtl/brx_datapath.sv
module brx_datapath
  import brx_pkg::*;
#(
  parameter int             ADDR_W      = 32,
  parameter int             BR_DISP_W   = 22,
  parameter int             CALL_DISP_W = 30,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   instValid,
  input  ctlStrobe_t             strobe,
  input  logic [CALL_DISP_W-1:0] dispBits,
  input  logic [ADDR_W-1:0]      jmpSum,
  output logic [ADDR_W-1:0]      pcQ,
  output logic [ADDR_W-1:0]      npcQ
);

  localparam int WORD_SH = 2;
  localparam int BR_EXT  = ADDR_W - BR_DISP_W - WORD_SH;
  localparam int CALL_EXT = ADDR_W - CALL_DISP_W - WORD_SH;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

  logic [ADDR_W-1:0] brOffset, callOffset, target, npcNext;

  assign brOffset = {{BR_EXT{dispBits[BR_DISP_W-1]}}, dispBits[BR_DISP_W-1:0],
                     {WORD_SH{1'b0}}};

  generate
    if (CALL_EXT > 0) begin : g_callExt
      assign callOffset = {{CALL_EXT{dispBits[CALL_DISP_W-1]}}, dispBits,
                           {WORD_SH{1'b0}}};
    end else begin : g_callFull
      assign callOffset = {dispBits, {WORD_SH{1'b0}}};
    end
  endgenerate

  always_comb begin
    unique case (strobe.tgtSel)
      TGT_CALL: target = pcQ + callOffset;
      TGT_REG:  target = jmpSum;
      default:  target = pcQ + brOffset;
    endcase
    npcNext = strobe.take ? target : npcQ + STEP;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pcQ  <= RESET_PC;
      npcQ <= RESET_PC + STEP;
    end else if (instValid) begin
      pcQ  <= npcQ;
      npcQ <= npcNext;
    end
  end

endmodule

// File: rtl/brx_top.sv
module brx_top
  import brx_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int BR_DISP_W   = 22,
  parameter int CALL_DISP_W = 30,
  parameter int LINK_REG    = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instValid,
  input  logic [31:0]       instWord,
  input  logic              flagN,
  input  logic              flagZ,
  input  logic              flagV,
  input  logic              flagC,
  input  logic [ADDR_W-1:0] jmpSum,
  output logic [ADDR_W-1:0] curPc,
  output logic [ADDR_W-1:0] nextPc,
  output logic              taken,
  output logic              annul,
  output logic              linkWe,
  output logic [4:0]        linkIdx,
  output logic [ADDR_W-1:0] linkData
);

  localparam int HI_LSB = 19;

  ctlStrobe_t strobe;

  brx_control #(.HI_LSB(HI_LSB), .LINK_REG(LINK_REG)) u_ctl (
    .instValid (instValid),
    .instHi    (instWord[31:HI_LSB]),
    .flagN     (flagN),
    .flagZ     (flagZ),
    .flagV     (flagV),
    .flagC     (flagC),
    .strobe    (strobe),
    .annul     (annul),
    .linkWe    (linkWe),
    .linkIdx   (linkIdx)
  );

  brx_datapath #(
    .ADDR_W(ADDR_W), .BR_DISP_W(BR_DISP_W), .CALL_DISP_W(CALL_DISP_W)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .instValid (instValid),
    .strobe    (strobe),
    .dispBits  (instWord[CALL_DISP_W-1:0]),
    .jmpSum    (jmpSum),
    .pcQ       (curPc),
    .npcQ      (nextPc)
  );

  assign taken    = strobe.take;
  assign linkData = curPc;

endmodule

// File: rtl/brx_checker.sv
module brx_checker (
  input logic        clk,
  input logic        rst,
  input logic        instValid,
  input logic [31:0] instWord,
  input logic [31:0] jmpSum,
  input logic [31:0] curPc,
  input logic [31:0] nextPc,
  input logic        taken,
  input logic        annul,
  input logic        linkWe,
  input logic [4:0]  linkIdx,
  input logic [31:0] linkData
);

  logic isBr, isCallW, isJmplW;
  assign isBr    = (instWord[31:30] == 2'b00) && (instWord[24:22] == 3'b010);
  assign isCallW = (instWord[31:30] == 2'b01);
  assign isJmplW = (instWord[31:30] == 2'b10) && (instWord[24:19] == 6'b111000);

  p_advance_r2: assert property (@(posedge clk) disable iff (rst)
    instValid && !taken |=> curPc == $past(nextPc) && nextPc == $past(nextPc) + 32'd4);

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !instValid |=> $stable(curPc) && $stable(nextPc));

  p_delay_slot_r4: assert property (@(posedge clk) disable iff (rst)
    instValid && taken && isBr |=> curPc == $past(nextPc) &&
      nextPc == $past(curPc + {{8{instWord[21]}}, instWord[21:0], 2'b00}));

  p_annul_off_r5: assert property (@(posedge clk) disable iff (rst)
    instValid && isBr && !instWord[29] |-> !annul);

  p_ba_annul_r6: assert property (@(posedge clk) disable iff (rst)
    instValid && isBr && instWord[29] && instWord[28:25] == 4'h8 |-> taken && annul);

  p_call_link_r7: assert property (@(posedge clk) disable iff (rst)
    instValid && isCallW |-> taken && linkWe && linkIdx == 5'd15 && linkData == curPc);

  p_call_target_r7: assert property (@(posedge clk) disable iff (rst)
    instValid && isCallW |=> nextPc == $past(curPc + {instWord[29:0], 2'b00}));

  p_jmpl_r8: assert property (@(posedge clk) disable iff (rst)
    instValid && isJmplW |=> nextPc == $past(jmpSum) && curPc == $past(nextPc));

  p_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !instValid || !(isBr || isCallW || isJmplW) |-> !taken && !annul && !linkWe);

endmodule

bind brx_top brx_checker u_brxChk (
  .clk(clk), .rst(rst), .instValid(instValid), .instWord(instWord),
  .jmpSum(jmpSum), .curPc(curPc), .nextPc(nextPc), .taken(taken),
  .annul(annul), .linkWe(linkWe), .linkIdx(linkIdx), .linkData(linkData)
);

// File: tb/sim_brx_top.sv
module sim_brx_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instValid = 1'b0;
  logic [31:0] instWord = '0;
  logic        flagN = 0, flagZ = 0, flagV = 0, flagC = 0;
  logic [31:0] jmpSum = '0;
  logic [31:0] curPc, nextPc, linkData;
  logic        taken, annul, linkWe;
  logic [4:0]  linkIdx;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] mPc, mNpc;

  always #4 clk = ~clk;

  brx_top u0 (
    .clk(clk), .rst(rst), .instValid(instValid), .instWord(instWord),
    .flagN(flagN), .flagZ(flagZ), .flagV(flagV), .flagC(flagC),
    .jmpSum(jmpSum), .curPc(curPc), .nextPc(nextPc), .taken(taken),
    .annul(annul), .linkWe(linkWe), .linkIdx(linkIdx), .linkData(linkData)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit refCond(input logic [3:0] c, input bit n, input bit z,
                                 input bit v, input bit cy);
    case (c)
      4'h0: return 0;
      4'h1: return z;
      4'h2: return z | (n ^ v);
      4'h3: return n ^ v;
      4'h4: return cy | z;
      4'h5: return cy;
      4'h6: return n;
      4'h7: return v;
      4'h8: return 1;
      4'h9: return !z;
      4'hA: return !(z | (n ^ v));
      4'hB: return !(n ^ v);
      4'hC: return !(cy | z);
      4'hD: return !cy;
      4'hE: return !n;
      default: return !v;
    endcase
  endfunction

  function automatic logic [31:0] brWord(input bit a, input logic [3:0] c,
                                         input logic [21:0] d);
    return {2'b00, a, c, 3'b010, d};
  endfunction

  // drive one step, check same-cycle outputs, then the registered state
  task automatic issue(input bit v, input logic [31:0] w, input logic [3:0] f,
                       input logic [31:0] sum, input bit eTaken, input bit eAnnul,
                       input bit eLink, input logic [4:0] eIdx,
                       input logic [31:0] eTgt, input string tag);
    @(negedge clk);
    instValid = v; instWord = w; jmpSum = sum;
    {flagN, flagZ, flagV, flagC} = f;
    #1;
    chk(taken == eTaken, {tag, " taken"}, 32'(taken), 32'(eTaken));
    chk(annul == eAnnul, {tag, " annul"}, 32'(annul), 32'(eAnnul));
    chk(linkWe == eLink, {tag, " linkWe"}, 32'(linkWe), 32'(eLink));
    if (eLink) begin
      chk(linkIdx == eIdx, {tag, " linkIdx"}, 32'(linkIdx), 32'(eIdx));
      chk(linkData == mPc, {tag, " linkData"}, linkData, mPc);
    end
    @(posedge clk); #1;
    if (v) begin
      mPc  = mNpc;
      mNpc = eTaken ? eTgt : mNpc + 32'd4;
    end
    chk(curPc == mPc, {tag, " curPc"}, curPc, mPc);
    chk(nextPc == mNpc, {tag, " nextPc"}, nextPc, mNpc);
    @(negedge clk);
    instValid = 0;
  endtask

  task automatic testReset();
    chk(curPc == 32'd0, "R1 reset curPc", curPc, 32'd0);
    chk(nextPc == 32'd4, "R1 reset nextPc", nextPc, 32'd4);
    mPc = 0; mNpc = 4;
  endtask

  task automatic testSequential();
    issue(1, 32'h8000_0000, 4'h0, 0, 0, 0, 0, 0, 0, "R2/R9 plain op");
    issue(0, brWord(0, 4'h8, 22'h10), 4'h0, 0, 0, 0, 0, 0, 0, "R2/R9 idle strobe");
    issue(1, {2'b00, 1'b0, 4'h8, 3'b100, 22'h10}, 4'h0, 0, 0, 0, 0, 0, 0,
          "R9 non-branch op2");
  endtask

  task automatic testConditions();
    for (int c = 0; c < 16; c++) begin
      for (int k = 0; k < 12; k++) begin
        logic [3:0] f = 4'($urandom);
        bit t = refCond(4'(c), f[3], f[2], f[1], f[0]);
        issue(1, brWord(0, 4'(c), 22'h8), f, 0, t, 0, 0, 0, mPc + 32'd32,
              $sformatf("R3 cond %0h flags %b", c, f));
      end
    end
  endtask

  task automatic testDisplacement();
    issue(1, brWord(0, 4'h8, 22'h00_0010), 4'h0, 0, 1, 0, 0, 0, mPc + 32'd64,
          "R4 forward");
    issue(1, 32'h8000_0000, 4'h0, 0, 0, 0, 0, 0, 0, "R4 delay slot step");
    issue(1, brWord(0, 4'h8, 22'h3F_FFF0), 4'h0, 0, 1, 0, 0, 0, mPc - 32'd64,
          "R4 backward");
    issue(1, brWord(0, 4'h8, 22'h20_0000), 4'h0, 0, 1, 0, 0, 0,
          mPc - 32'h0080_0000, "R4 max backward");
    issue(1, brWord(0, 4'h8, 22'h1F_FFFF), 4'h0, 0, 1, 0, 0, 0,
          mPc + 32'h007F_FFFC, "R4 max forward");
  endtask

  task automatic testAnnul();
    issue(1, brWord(1, 4'h1, 22'h4), 4'b0000, 0, 0, 1, 0, 0, 0, "R5 annul not taken");
    issue(1, brWord(1, 4'h1, 22'h4), 4'b0100, 0, 1, 0, 0, 0, mPc + 32'd16,
          "R6 annul cond taken");
    issue(1, brWord(0, 4'h1, 22'h4), 4'b0000, 0, 0, 0, 0, 0, 0, "R5 no annul bit");
    issue(1, brWord(1, 4'h8, 22'h4), 4'b0000, 0, 1, 1, 0, 0, mPc + 32'd16,
          "R6 always annul");
    issue(1, brWord(1, 4'h0, 22'h4), 4'b1111, 0, 0, 1, 0, 0, 0, "R5 never annul");
  endtask

  task automatic testCall();
    issue(1, {2'b01, 30'h0000_0100}, 4'h0, 0, 1, 0, 1, 5'd15, mPc + 32'h400,
          "R7 call forward");
    issue(1, {2'b01, 30'h3FFF_FFFF}, 4'h0, 0, 1, 0, 1, 5'd15, mPc - 32'd4,
          "R7 call backward");
  endtask

  task automatic testJmpl();
    issue(1, {2'b10, 5'd7, 6'b111000, 19'h1ABC}, 4'h0, 32'hCAFE_0010,
          1, 0, 1, 5'd7, 32'hCAFE_0010, "R8 jmpl rd7");
    issue(1, {2'b10, 5'd31, 6'b111000, 19'h0}, 4'h0, 32'h0000_2000,
          1, 0, 1, 5'd31, 32'h0000_2000, "R8 jmpl rd31");
    issue(1, {2'b10, 5'd3, 6'b111001, 19'h0}, 4'h0, 32'h1234_0000,
          0, 0, 0, 0, 0, "R9 other arith op");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    #1 testReset();
    testSequential();
    testConditions();
    testDisplacement();
    testAnnul();
    testCall();
    testJmpl();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule